// File: doc/BRIEF.md
# Fault Interrupt One-Shot

This block watches a vector of fault flags and raises a single interrupt pulse of fixed length when any flag becomes newly set. The flags themselves are held and read out by other logic over a serial link; this block only tells the host that something has happened, so the host can go and read them.

A new fault is a flag that was clear on the previous clock and is set on this one. When such an event is seen while the block is idle, the interrupt output is asserted for a number of system clocks set by a parameter. While the pulse runs, the trigger is locked out. A flag that becomes set inside that window neither stretches the pulse nor queues a second one; it stays visible only through the serial readout.

The interrupt line is active-low and open-drain, so that several devices can share one host interrupt by wired-OR. Here it is modelled as an output enable: while the enable is high, the pin is pulled low. While the enable is low, the pin is released. The block never drives the line high.

Top module: `fault_irq_oneshot`

## Requirements
- R1: While the block is idle, a flag that goes from 0 to 1 starts a pulse. `intPullEn` is 1 in the clock cycle that follows the rising clock edge at which the set flag was first sampled.
- R2: Every pulse holds `intPullEn` at 1 for exactly `PULSE_CYCLES` consecutive clock cycles and then returns it to 0.
- R3: While a pulse is active, including its final cycle, a newly set flag does not lengthen the pulse and does not start a later pulse.
- R4: Only a 0-to-1 change of a flag triggers. A flag that stays at 1 does not trigger, including when it is still set as a pulse ends. A flag that falls from 1 to 0 does not trigger.
- R5: Several flags that become set on the same clock give one pulse.
- R6: While `rstN` is 0, `intPullEn` is 0 at once (asynchronous), and any active pulse is abandoned. The stored copy of the previous flags is cleared, so a flag held at 1 through reset counts as a new fault after release.
- R7: A flag that becomes set on the first idle cycle after a pulse ends starts a new full pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultIn | input | NUM_FLAGS (8) | Fault flag vector; bit i high means fault i is present |
| intPullEn | output | 1 | 1 = pull the shared open-drain interrupt line low |

## Verification
The bench goes after the edges of the lockout window. A fault rising on the very last pulse cycle must be swallowed; a design that samples the trigger there would either stretch the pulse or emit a back-to-back second one. A fault rising on the first cycle after the window must start a fresh pulse, which an off-by-one lockout would miss. Flags held high across the end of a pulse and across reset probe the previous-value store: a level-sensitive design would pulse forever, and a store that survives reset would miss faults present at start-up. Simultaneous multi-flag sets and falling flags check that one event gives one pulse and that clears never trigger.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;  // start a new pulse window
    logic decCnt;   // count one cycle of the window away
  } ctlStrobes_t;
endpackage

// File: rtl/fault_irq_dp.sv
module fault_irq_dp
  import fault_irq_pkg::*;
#(
  parameter int NUM_FLAGS    = 8,
  parameter int PULSE_CYCLES = 16,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] faultIn,
  input  ctlStrobes_t          strobes,
  output logic                 newSetAny,
  output logic                 countZero
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  logic [NUM_FLAGS-1:0] prevFault;
  logic [NUM_FLAGS-1:0] riseVec;
  logic [CNT_W-1:0]     cnt;

  // previous-value store, updated every cycle (also inside the lockout)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevFault <= '0;
    else       prevFault <= faultIn;
  end

  // per-flag set-event detection
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_rise
    assign riseVec[i] = faultIn[i] & ~prevFault[i];
  end

  assign newSetAny = |riseVec;

  // window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobes.loadCnt) cnt <= LOAD_VAL;
    else if (strobes.decCnt)  cnt <= cnt - 1'b1;
  end

  assign countZero = (cnt == '0);

  // R2
  load_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> (cnt == LOAD_VAL));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decCnt && !strobes.loadCnt) |=> (cnt == $past(cnt) - 1'b1));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadCnt && strobes.decCnt));
endmodule

// File: rtl/fault_irq_ctl.sv
module fault_irq_ctl
  import fault_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        newSetAny,
  input  logic        countZero,
  output ctlStrobes_t strobes,
  output logic        pulseActive
);
  typedef enum logic {ST_IDLE, ST_PULSE} state_t;
  state_t state, stateNxt;

  always_comb begin
    stateNxt        = state;
    strobes.loadCnt = 1'b0;
    strobes.decCnt  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (newSetAny) begin
          strobes.loadCnt = 1'b1;
          stateNxt        = ST_PULSE;
        end
      end
      ST_PULSE: begin
        // triggers are ignored in every cycle of the window
        if (countZero) stateNxt = ST_IDLE;
        else           strobes.decCnt = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign pulseActive = (state == ST_PULSE);

  // R1
  start_on_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseActive && newSetAny) |=> pulseActive);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseActive && !newSetAny) |=> !pulseActive);

  // R2
  hold_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !countZero) |=> pulseActive);

  // R3
  lockout_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && countZero) |=> !pulseActive);

  // R3
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> !strobes.loadCnt);
endmodule

// File: rtl/fault_irq_oneshot.sv
module fault_irq_oneshot
  import fault_irq_pkg::*;
#(
  parameter int NUM_FLAGS    = 8,
  parameter int PULSE_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] faultIn,
  output logic                 intPullEn
);
  ctlStrobes_t strobes;
  logic        newSetAny;
  logic        countZero;
  logic        pulseActive;

  fault_irq_dp #(
    .NUM_FLAGS   (NUM_FLAGS),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .faultIn  (faultIn),
    .strobes  (strobes),
    .newSetAny(newSetAny),
    .countZero(countZero)
  );

  fault_irq_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .newSetAny  (newSetAny),
    .countZero  (countZero),
    .strobes    (strobes),
    .pulseActive(pulseActive)
  );

  assign intPullEn = pulseActive;

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> !intPullEn);
endmodule

// File: tb/sim_fault_irq_oneshot.sv
module sim_fault_irq_oneshot;
  localparam int NF = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NF-1:0] faultIn = '0;
  logic          intPullEn;

  int     nTests = 0;
  int     nFail  = 0;
  string  curReq = "R6";
  bit     done   = 1'b0;

  // reference model state
  int          remM;
  logic [NF-1:0] prevM;
  // pulse monitor
  int pulseCnt = 0;
  int curWidth = 0;
  int lastWidth = 0;
  logic lastOut = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fault_irq_oneshot #(.NUM_FLAGS(NF), .PULSE_CYCLES(PW)) u0 (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .intPullEn(intPullEn)
  );

  // behavioural reference: remaining pulse cycles
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remM  <= 0;
      prevM <= '0;
    end else begin
      if (remM > 0) remM <= remM - 1;
      else if ((faultIn & ~prevM) != '0) remM <= PW;
      prevM <= faultIn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare and pulse monitor, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(intPullEn == (remM > 0), curReq, int'(intPullEn), int'(remM > 0));
      if (intPullEn && !lastOut) pulseCnt++;
      if (intPullEn) curWidth++;
      else if (lastOut) begin lastWidth = curWidth; curWidth = 0; end
      lastOut = intPullEn;
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    int p0;
    step(3);
    check(intPullEn == 1'b0, "R6 reset state", int'(intPullEn), 0);
    rstN = 1'b1;
    step(3);
    check(pulseCnt == 0, "R4 idle no pulse", pulseCnt, 0);

    // R1 / R2: single flag
    curReq = "R1";
    faultIn[2] = 1'b1;
    step(1);
    check(intPullEn == 1'b1, "R1 starts after edge", int'(intPullEn), 1);
    curReq = "R2";
    step(PW + 2);
    check(pulseCnt == 1, "R1 one pulse", pulseCnt, 1);
    check(lastWidth == PW, "R2 width", lastWidth, PW);

    // R3 inside window; R4 held flag at end
    curReq = "R3";
    p0 = pulseCnt;
    faultIn[0] = 1'b1;
    step(5);
    faultIn[5] = 1'b1;
    step(PW + 4);
    check(pulseCnt == p0 + 1, "R3 no second pulse", pulseCnt, p0 + 1);
    check(lastWidth == PW, "R3 not stretched", lastWidth, PW);
    curReq = "R4";
    step(6);
    check(pulseCnt == p0 + 1, "R4 held flag no retrigger", pulseCnt, p0 + 1);
    faultIn = '0;
    step(6);
    check(pulseCnt == p0 + 1, "R4 falling flags ignored", pulseCnt, p0 + 1);

    // R5 simultaneous
    curReq = "R5";
    p0 = pulseCnt;
    faultIn = 8'b1000_1001;
    step(PW + 4);
    check(pulseCnt == p0 + 1, "R5 single pulse", pulseCnt, p0 + 1);
    check(lastWidth == PW, "R5 width", lastWidth, PW);

    // R3 final cycle, R7 first idle cycle
    faultIn = '0;
    step(3);
    curReq = "R3";
    p0 = pulseCnt;
    faultIn[1] = 1'b1;       // sampled at edge e0
    step(PW);                // now inside the last pulse cycle
    faultIn[4] = 1'b1;       // sampled at e16: locked out
    step(1);
    check(intPullEn == 1'b0, "R3 final-cycle set swallowed", int'(intPullEn), 0);
    curReq = "R7";
    faultIn[6] = 1'b1;       // sampled at e17: idle
    step(1);
    check(intPullEn == 1'b1, "R7 restart on first idle cycle", int'(intPullEn), 1);
    step(PW + 2);
    check(pulseCnt == p0 + 2, "R7 two pulses", pulseCnt, p0 + 2);
    check(lastWidth == PW, "R7 full width", lastWidth, PW);

    // R6 reset mid pulse with flags held
    curReq = "R6";
    faultIn = '0;
    step(2);
    faultIn[3] = 1'b1;
    step(4);
    rstN = 1'b0;
    #1;
    check(intPullEn == 1'b0, "R6 async abort", int'(intPullEn), 0);
    step(3);
    curWidth = 0;
    lastOut = 1'b0;
    p0 = pulseCnt;
    rstN = 1'b1;
    step(2);
    check(intPullEn == 1'b1, "R6 held flag retriggers after reset", int'(intPullEn), 1);
    step(PW + 3);
    check(pulseCnt == p0 + 1, "R6 one pulse after release", pulseCnt, p0 + 1);
    check(lastWidth == PW, "R6 width after release", lastWidth, PW);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule